// File: doc/BRIEF.md
# Streaming Signed Requantizer

This block narrows signed two's-complement samples that travel in a stream qualified by a valid flag. Each sample first loses a fixed number of low-order bits. These bits are either rounded or simply truncated. The block then fits the remaining high-order part into the output width. It does this either by saturating at the range limits or by discarding the surplus high bits, which makes the value wrap. A packet-start flag and a packet-end flag travel through the block beside the data.

The block carries either one real lane or two lanes, one real and one imaginary. The two lanes are processed independently with the same settings. Every option is fixed at elaboration: input width, number of dropped bits, output width, rounding or truncation, saturation of a rounding overflow, clipping or wrapping, and symmetric or asymmetric clipping. Data and flags emerge exactly two clock cycles after they enter. Output data reads zero in every cycle where the output valid is low.

Top module: `stream_requant`

## Requirements
- R1: `out_valid`, `out_sop` and `out_eop` equal `in_valid`, `in_sop` and `in_eop` as sampled two rising clock edges earlier, for any pattern including back-to-back samples and gaps.
- R2: While `out_valid` is 0, `out_re` and `out_im` are all zeros, whatever data was presented while `in_valid` was 0.
- R3: With `ROUND_EN`=1, the `DROP_W` low bits are rounded half away from zero: +2.5 LSB of the kept part becomes 3, -2.5 becomes -3, +2.4375 becomes 2, -0.4375 becomes 0.
- R4: With `ROUND_EN`=0, the low bits are truncated toward minus infinity: +2.5 becomes 2 and -2.5 becomes -3.
- R5: With `ROUND_SAT`=0, a positive value that rounds past the largest kept value wraps to the most negative kept value. Clipping then turns it into the most negative output.
- R6: With `ROUND_SAT`=1, such a rounding overflow becomes the largest positive kept value instead. A non-negative input then never gives a negative output when clipping is on.
- R7: With `HI_CLIP`=1 and `CLIP_SYM`=0, kept values above 2^(OUT_W-1)-1 give that value, and kept values below -2^(OUT_W-1) give -2^(OUT_W-1).
- R8: With `HI_CLIP`=1 and `CLIP_SYM`=1, the negative limit is -(2^(OUT_W-1)-1). The output code 1 followed by OUT_W-1 zeros never appears.
- R9: With `HI_CLIP`=0, the output is the low `OUT_W` bits of the kept value read as two's complement. `CLIP_SYM` has no effect in this mode.
- R10: With `COMPLEX`=1, `out_im` is computed from `in_im` exactly as `out_re` is from `in_re`, and neither lane influences the other.
- R11: With `COMPLEX`=0, `in_im` is ignored and `out_im` is always zero.
- R12: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample qualifier |
| in_sop | input | 1 | Input packet-start flag |
| in_eop | input | 1 | Input packet-end flag |
| in_re | input | IN_W | Real part, signed |
| in_im | input | IN_W | Imaginary part, signed (used when COMPLEX=1) |
| out_valid | output | 1 | Output sample qualifier |
| out_sop | output | 1 | Output packet-start flag |
| out_eop | output | 1 | Output packet-end flag |
| out_re | output | OUT_W | Requantized real part, signed |
| out_im | output | OUT_W | Requantized imaginary part, signed (zero when COMPLEX=0) |

## Verification
The block keeps no state beyond its two pipeline registers, so any internal fault shows at the ports within two cycles of the sample that exposes it. A wrong rounding bias or overflow handling in the first stage produces an output value off by one LSB, or one with the wrong sign, exactly two cycles after the offending input. A fault in the range check of the second stage shows the next cycle as a value outside the clip limits or an unexpected wrap. A slip in the flag pipeline shows as valid or packet markers arriving a cycle early or late, or as non-zero data during an idle cycle.

// File: rtl/sreq_pkg.sv
package sreq_pkg;

    // Sideband flags that travel beside each sample
    typedef struct packed {
        logic valid;
        logic sop;
        logic eop;
    } sreq_ctrl_t;

    // Number of data lanes for a given complex setting
    function automatic int lane_count(bit cpx);
        return cpx ? 2 : 1;
    endfunction

endpackage

// File: rtl/sreq_round.sv
// Low-bit removal for one lane: adds a rounding bias (or none), drops DROP_W
// bits, and optionally saturates a positive overflow of the kept part.
module sreq_round #(
    parameter int IN_W      = 28,
    parameter int DROP_W    = 16,
    parameter bit ROUND_EN  = 1'b1,
    parameter bit ROUND_SAT = 1'b0,
    localparam int KEEP_W   = IN_W - DROP_W
) (
    input  logic [IN_W-1:0]   din,
    output logic [KEEP_W-1:0] dout
);

    generate
        if (DROP_W == 0) begin : g_pass
            assign dout = din;
        end else begin : g_drop
            localparam logic [IN_W:0] HALF_D = (IN_W+1)'(1) << (DROP_W - 1);
            localparam logic [KEEP_W-1:0] KEEP_MAX = {1'b0, {(KEEP_W-1){1'b1}}};

            logic [IN_W:0]   ext_d;
            logic [IN_W:0]   bias_d;
            logic [IN_W:0]   sum_d;
            logic [KEEP_W:0] kept_d;
            logic            ovf_d;

            always_comb begin
                ext_d  = {din[IN_W-1], din};
                bias_d = '0;
                if (ROUND_EN) begin
                    // half away from zero: negative values get just under half
                    bias_d = din[IN_W-1] ? (HALF_D - (IN_W+1)'(1)) : HALF_D;
                end
                sum_d  = ext_d + bias_d;
                kept_d = (KEEP_W+1)'(sum_d >> DROP_W);
                // only a positive value can leave the kept range
                ovf_d  = kept_d[KEEP_W] ^ kept_d[KEEP_W-1];
                if (ovf_d && ROUND_SAT) begin
                    dout = KEEP_MAX;
                end else begin
                    dout = kept_d[KEEP_W-1:0];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/sreq_narrow.sv
// High-bit reduction for one lane: saturate (symmetric or not) or wrap.
module sreq_narrow #(
    parameter int KEEP_W   = 12,
    parameter int OUT_W    = 8,
    parameter bit HI_CLIP  = 1'b1,
    parameter bit CLIP_SYM = 1'b0
) (
    input  logic [KEEP_W-1:0] din,
    output logic [OUT_W-1:0]  dout
);

    localparam logic [OUT_W-1:0] POS_MAX  = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] NEG_TRUE = {1'b1, {(OUT_W-1){1'b0}}};
    localparam logic [OUT_W-1:0] NEG_LIM  = CLIP_SYM ? (NEG_TRUE + OUT_W'(1)) : NEG_TRUE;

    logic             fits_d;
    logic [OUT_W-1:0] low_d;

    generate
        if (KEEP_W > OUT_W) begin : g_wide
            logic [KEEP_W-OUT_W:0] top_d;
            assign top_d  = din[KEEP_W-1:OUT_W-1];
            // in range when all discarded bits equal the new sign bit
            assign fits_d = (&top_d) | ~(|top_d);
        end else begin : g_same
            assign fits_d = 1'b1;
        end
    endgenerate

    assign low_d = din[OUT_W-1:0];

    always_comb begin
        dout = low_d;
        if (HI_CLIP) begin
            if (!fits_d) begin
                dout = din[KEEP_W-1] ? NEG_LIM : POS_MAX;
            end else if (low_d == NEG_TRUE) begin
                dout = NEG_LIM;
            end
        end
    end

endmodule

// File: rtl/stream_requant.sv
module stream_requant
    import sreq_pkg::*;
#(
    parameter int IN_W      = 28,
    parameter int DROP_W    = 16,
    parameter int OUT_W     = 8,
    parameter bit ROUND_EN  = 1'b1,
    parameter bit ROUND_SAT = 1'b0,
    parameter bit HI_CLIP   = 1'b1,
    parameter bit CLIP_SYM  = 1'b0,
    parameter bit COMPLEX   = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic [IN_W-1:0]  in_re,
    input  logic [IN_W-1:0]  in_im,
    output logic             out_valid,
    output logic             out_sop,
    output logic             out_eop,
    output logic [OUT_W-1:0] out_re,
    output logic [OUT_W-1:0] out_im
);

    localparam int KEEP_W = IN_W - DROP_W;
    localparam int NL     = lane_count(COMPLEX);
    localparam logic [OUT_W-1:0] NEG_CODE = {1'b1, {(OUT_W-1){1'b0}}};

    typedef struct packed {
        sreq_ctrl_t                   c1;   // after rounding stage
        logic [NL-1:0][KEEP_W-1:0]    mid;
        sreq_ctrl_t                   c2;   // after narrowing stage
        logic [NL-1:0][OUT_W-1:0]     res;
    } pipe_t;

    pipe_t st_d, st_q;

    logic [NL-1:0][IN_W-1:0]   lane_in;
    logic [NL-1:0][KEEP_W-1:0] lane_rnd;
    logic [NL-1:0][OUT_W-1:0]  lane_nar;

    assign lane_in[0] = in_re;
    generate
        if (NL == 2) begin : g_im_in
            assign lane_in[NL-1] = in_im;
        end
    endgenerate

    generate
        for (genvar l = 0; l < NL; l++) begin : g_lane
            sreq_round #(
                .IN_W     (IN_W),
                .DROP_W   (DROP_W),
                .ROUND_EN (ROUND_EN),
                .ROUND_SAT(ROUND_SAT)
            ) u_round (
                .din (lane_in[l]),
                .dout(lane_rnd[l])
            );

            sreq_narrow #(
                .KEEP_W  (KEEP_W),
                .OUT_W   (OUT_W),
                .HI_CLIP (HI_CLIP),
                .CLIP_SYM(CLIP_SYM)
            ) u_narrow (
                .din (st_q.mid[l]),
                .dout(lane_nar[l])
            );
        end
    endgenerate

    always_comb begin
        st_d          = st_q;
        st_d.c1.valid = in_valid;
        st_d.c1.sop   = in_sop;
        st_d.c1.eop   = in_eop;
        st_d.mid      = in_valid ? lane_rnd : '0;
        st_d.c2       = st_q.c1;
        st_d.res      = st_q.c1.valid ? lane_nar : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.c2.valid;
    assign out_sop   = st_q.c2.sop;
    assign out_eop   = st_q.c2.eop;
    assign out_re    = st_q.res[0];

    generate
        if (NL == 2) begin : g_im_out
            assign out_im = st_q.res[NL-1];
        end else begin : g_im_zero
            assign out_im = '0;
        end
    endgenerate

    // Cycles since reset release, saturating at 2; gates the delay checks
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_q <= 2'd0;
        end else if (warm_q != 2'd2) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    // R1: flags leave two edges after they enter
    a_r1_flag_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |->
            ({out_valid, out_sop, out_eop} == $past({in_valid, in_sop, in_eop}, 2)));

    // R2: idle cycles carry zero data
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ((out_re == '0) && (out_im == '0)));

    // R8: symmetric clipping never emits the most negative code
    a_r8_sym_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (HI_CLIP && CLIP_SYM && out_valid) |->
            ((out_re != NEG_CODE) && (out_im != NEG_CODE)));

    // R6: saturated rounding keeps a non-negative input non-negative
    a_r6_sat_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (ROUND_SAT && HI_CLIP && (warm_q == 2'd2) && out_valid) |->
            ($past(in_re[IN_W-1], 2) || !out_re[OUT_W-1]));

endmodule

// File: tb/stream_requant_bench.sv
module stream_requant_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic [27:0] big_re = '0;
    logic [27:0] big_im = '0;
    logic [11:0] sm_re = '0;
    logic [11:0] sm_im = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // default configuration: round, wrap on round overflow, asymmetric clip, complex
    logic       a_v, a_s, a_e;
    logic [7:0] a_re, a_im;
    stream_requant u_stream_requant (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .in_re(big_re), .in_im(big_im),
        .out_valid(a_v), .out_sop(a_s), .out_eop(a_e), .out_re(a_re), .out_im(a_im)
    );

    // round, saturate round overflow, symmetric clip, complex
    logic       b_v, b_s, b_e;
    logic [4:0] b_re, b_im;
    stream_requant #(
        .IN_W(12), .DROP_W(4), .OUT_W(5), .ROUND_EN(1'b1), .ROUND_SAT(1'b1),
        .HI_CLIP(1'b1), .CLIP_SYM(1'b1), .COMPLEX(1'b1)
    ) u_sat_sym (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .in_re(sm_re), .in_im(sm_im),
        .out_valid(b_v), .out_sop(b_s), .out_eop(b_e), .out_re(b_re), .out_im(b_im)
    );

    // truncate, wrap (symmetric option set but irrelevant), real only
    logic       c_v, c_s, c_e;
    logic [4:0] c_re, c_im;
    stream_requant #(
        .IN_W(12), .DROP_W(4), .OUT_W(5), .ROUND_EN(1'b0), .ROUND_SAT(1'b0),
        .HI_CLIP(1'b0), .CLIP_SYM(1'b1), .COMPLEX(1'b0)
    ) u_trunc_wrap (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .in_re(sm_re), .in_im(sm_im),
        .out_valid(c_v), .out_sop(c_s), .out_eop(c_e), .out_re(c_re), .out_im(c_im)
    );

    // reference model written from the requirements
    function automatic longint ref_q(longint raw, int iw, int d, int ow,
                                     bit rnd, bit rsat, bit clip, bit sym);
        longint one = 1;
        longint x, q, maxk, maxo, mino, m;
        x = raw & ((one << iw) - 1);
        if (x >= (one << (iw - 1))) x = x - (one << iw);
        if (rnd) x = x + ((x >= 0) ? (one << (d - 1)) : ((one << (d - 1)) - 1));
        q = x >>> d;
        maxk = (one << (iw - d - 1)) - 1;
        if (q > maxk) q = rsat ? maxk : q - (one << (iw - d));
        maxo = (one << (ow - 1)) - 1;
        if (clip) begin
            mino = sym ? -maxo : -maxo - 1;
            if (q > maxo) q = maxo;
            if (q < mino) q = mino;
        end else begin
            m = q & ((one << ow) - 1);
            if (m > maxo) m = m - (one << ow);
            q = m;
        end
        return q;
    endfunction

    function automatic longint sx(longint v, int w);
        longint one = 1;
        longint m;
        m = v & ((one << w) - 1);
        if (m >= (one << (w - 1))) m = m - (one << w);
        return m;
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // history of the last two driven steps; index 1 is due at the ports now
    bit     h_v[2], h_s[2], h_e[2];
    longint h_bre[2], h_bim[2], h_sre[2], h_sim[2];
    string  h_tag[2] = '{"R12 reset", "R12 reset"};

    task automatic check_due();
        string dt;
        bit    v;
        v  = h_v[1];
        dt = v ? h_tag[1] : "R2 idle";
        chk("R1", "a valid", a_v, v);  chk("R1", "a sop", a_s, h_s[1]);  chk("R1", "a eop", a_e, h_e[1]);
        chk("R1", "b valid", b_v, v);  chk("R1", "b sop", b_s, h_s[1]);  chk("R1", "b eop", b_e, h_e[1]);
        chk("R1", "c valid", c_v, v);  chk("R1", "c sop", c_s, h_s[1]);  chk("R1", "c eop", c_e, h_e[1]);
        chk(dt, "a re", sx(a_re, 8), v ? ref_q(h_bre[1], 28, 16, 8, 1, 0, 1, 0) : 0);
        chk(dt, "a im", sx(a_im, 8), v ? ref_q(h_bim[1], 28, 16, 8, 1, 0, 1, 0) : 0);
        chk(dt, "b re", sx(b_re, 5), v ? ref_q(h_sre[1], 12, 4, 5, 1, 1, 1, 1) : 0);
        chk(dt, "b im", sx(b_im, 5), v ? ref_q(h_sim[1], 12, 4, 5, 1, 1, 1, 1) : 0);
        chk(dt, "c re", sx(c_re, 5), v ? ref_q(h_sre[1], 12, 4, 5, 0, 0, 0, 1) : 0);
        chk("R11", "c im", sx(c_im, 5), 0);
    endtask

    task automatic step(bit v, bit s, bit e, longint bre, longint bim,
                        longint sre, longint sim, string tag);
        @(negedge clk);
        check_due();
        h_v[1] = h_v[0];   h_s[1] = h_s[0];   h_e[1] = h_e[0];
        h_bre[1] = h_bre[0]; h_bim[1] = h_bim[0]; h_sre[1] = h_sre[0]; h_sim[1] = h_sim[0];
        h_tag[1] = h_tag[0];
        h_v[0] = v; h_s[0] = s; h_e[0] = e;
        h_bre[0] = bre; h_bim[0] = bim; h_sre[0] = sre; h_sim[0] = sim; h_tag[0] = tag;
        in_valid = v; in_sop = s; in_eop = e;
        big_re = 28'(bre); big_im = 28'(bim); sm_re = 12'(sre); sm_im = 12'(sim);
    endtask

    task automatic flush();
        for (int i = 0; i < 2; i++) step(0, 0, 0, 0, 0, 0, 0, "R2 idle");
    endtask

    task automatic t_reset();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R12", "valid", a_v | b_v | c_v, 0);
            chk("R12", "flags", a_s | a_e | b_s | b_e | c_s | c_e, 0);
            chk("R12", "data", a_re | a_im, 0);
            chk("R12", "small data", b_re | b_im | c_re | c_im, 0);
        end
        rst_n = 1'b1;
    endtask

    task automatic t_round();
        step(1, 0, 0,  163840, -163840,  40, -40, "R3/R4 halves");
        step(1, 0, 0,  157286, -157286,  39, -39, "R3/R4 below half");
        step(1, 0, 0,   32768,  -32768,   8,  -8, "R3/R4 one half");
        step(1, 0, 0,   32767,  -32767,   7,  -7, "R3/R4 under half");
        step(1, 0, 0,       0,      -1,   0,  -1, "R3/R4 near zero");
        flush();
    endtask

    task automatic t_round_ovf();
        step(1, 0, 0, 134217727, 134184959, 2047, 2039, "R5/R6 round overflow");
        step(1, 0, 0, 134184960, 134217726, 2040, 2046, "R5/R6 overflow edge");
        flush();
    endtask

    task automatic t_clip();
        step(1, 0, 0,  13107200, -13107200,   300,  -300, "R7/R8 far beyond");
        step(1, 0, 0, -134217728, -8388608, -2048,  -256, "R7/R8 true minimum");
        step(1, 0, 0,   8323072,  -8454144,   240,  -240, "R7/R8 at limits");
        step(1, 0, 0,   8355840,  -8421376,   248,  -248, "R7/R8 round into limit");
        flush();
    endtask

    task automatic t_wrap();
        step(1, 0, 0, 0, 0,  320, 0, "R9 wrap positive");
        step(1, 0, 0, 0, 0, -272, 0, "R9 wrap negative");
        step(1, 0, 0, 0, 0,  256, 0, "R9 wrap to min code");
        flush();
    endtask

    task automatic t_complex();
        step(1, 0, 0,  327680, -458752,  100, -300, "R10 lanes differ");
        step(1, 0, 0, -458752,  327680, -300,  100, "R10 lanes swapped");
        step(1, 0, 0, 134217727, 0, 2047, 0, "R10 one lane saturating");
        flush();
    endtask

    task automatic t_real();
        step(1, 0, 0, 65536, 65536, 16, 2047, "R11 imaginary ignored");
        step(1, 0, 0, 65536, 65536, 16, -2048, "R11 imaginary ignored");
        flush();
    endtask

    task automatic t_stream();
        step(1, 1, 0,  65536, 131072,  16,  32, "R1 packet start");
        step(1, 0, 0, 196608, 262144,  48,  64, "R1 packet body");
        step(1, 0, 0, -65536, -131072, -16, -32, "R1 packet body");
        step(1, 0, 1, -196608, -262144, -48, -64, "R1 packet end");
        step(0, 0, 0, 999999, -999999, 555, -555, "R2 gap data");
        step(0, 1, 1, 777777, -777777, 333, -333, "R2 gap data");
        step(1, 1, 1, 98304, -98304, 24, -24, "R1 single sample packet");
        flush();
    endtask

    task automatic t_sweep();
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r0, r1, r2;
            r0 = $urandom();
            r1 = $urandom();
            r2 = $urandom();
            step(r2[0], r2[1] & r2[0], r2[2] & r2[0],
                 sx(r0, 28), sx({r1[15:0], r0[31:20]}, 28),
                 sx(r1[27:16], 12), sx(r2[31:20], 12), "R3/R4/R7/R8/R9 sweep");
        end
        flush();
    endtask

    initial begin
        void'($urandom(32'h5eed));
        t_reset();
        t_round();
        t_round_ovf();
        t_clip();
        t_wrap();
        t_complex();
        t_real();
        t_stream();
        t_sweep();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule